// File: doc/BRIEF.md
# BCD calendar counter with alarm

This block is a real-time calendar for a chip's always-on domain. A one-second tick input advances a seconds/minutes/hours count held in packed BCD, and rolling past 23:59:59 increments a 15-bit binary day number. Software reaches the calendar through a byte-wide register port with an 8-bit address, separate write and read strobes, and write and read data buses. Through this port it loads the time, programs an alarm, and reads the counters back.

The alarm holds a minute, an hour and a day value, and each of the three has its own compare enable. When the seconds roll over to 00, the new minute, hour and day are compared against the enabled alarm fields. A full match sets a sticky alarm flag. Software clears the flag by writing 1 to its bit. The interrupt output is the flag gated by an interrupt enable.

A counter update takes one clock cycle, and the calendar reports itself busy during that cycle. A register write that arrives while the calendar is busy is held in a one-entry buffer and applied in the next cycle. This way a load never collides with a carry chain.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, every register reads 0x00, `rdata_o` is 0x00, and both `busy_o` and `irq_o` are low.
- R2: Seconds (address 0x15) and minutes (0x16) count 00 to 59 in packed BCD, with the tens digit in bits 7:4. The low digit carries 09→10, and 59 wraps to 00 with a carry into the next field.
- R3: Hours (0x17) count 00 to 23 in packed BCD. The step 23→00 carries into the day count, and no other hour step does.
- R4: The day count is binary, with bits 7:0 at 0x18 and bits 14:8 at 0x19. Bit 7 of 0x19 reads 0 and its write value is dropped. The count wraps from 0x7FFF to 0.
- R5: Control bit 0 (at 0x14) is the calendar enable. A tick sampled while it is 0 changes no count.
- R6: Writes load the addressed register: alarm minute at 0x1A, alarm hour at 0x1B, and alarm day bits 7:0 at 0x1C with bits 14:8 at 0x1D. Any address outside 0x14..0x1D reads 0x00, and a write to such an address has no effect.
- R7: The control byte is laid out as follows: bit 7 busy (read-only), bit 6 reads 0, bit 5 day-compare enable, bit 4 hour-compare enable, bit 3 minute-compare enable, bit 2 alarm flag, bit 1 interrupt enable, bit 0 calendar enable.
- R8: A tick sampled with the enable set drives `busy_o` and control bit 7 high for exactly the next cycle. The counters take their new values at the end of that cycle.
- R9: A write that is sampled while the calendar is busy is applied one cycle later. Its value replaces the value that the count produced.
- R10: When the seconds roll to 00, the flag sets if at least one compare enable is set and every enabled field equals the new minute, hour or day. Fields whose enable is clear do not take part in the compare.
- R11: Writing 1 to control bit 2 clears the flag, and writing 0 leaves the flag unchanged. A match sets the flag only once: later ticks within the same matched minute do not set it again.
- R12: `irq_o` is high exactly when the flag and the interrupt enable are both 1.
- R13: `rdata_o` takes the addressed register's value at the clock edge that samples `rd_en_i`, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| busy_o | output | 1 | Counter update in progress |
| irq_o | output | 1 | Alarm interrupt |

## Verification
A wrong carry shows up at the register port at the first tick that crosses a digit, field or day boundary. The bench reads every field right after such ticks, so an error appears within one read of its cause. A flag that sets on the wrong compare, or that sets twice, shows up on `irq_o` in the cycle after the rollover edge, and also in the control byte read that follows. A write that is lost or misordered during the busy cycle shows up as the incremented value in place of the loaded one, on the very next read of that field.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  // register offsets: software decodes these, so they are fixed
  localparam logic [ADDR_W-1:0] RA_CTRL   = 8'h14;
  localparam logic [ADDR_W-1:0] RA_SEC    = 8'h15;
  localparam logic [ADDR_W-1:0] RA_MIN    = 8'h16;
  localparam logic [ADDR_W-1:0] RA_HOUR   = 8'h17;
  localparam logic [ADDR_W-1:0] RA_DAYLO  = 8'h18;
  localparam logic [ADDR_W-1:0] RA_DAYHI  = 8'h19;
  localparam logic [ADDR_W-1:0] RA_AMIN   = 8'h1A;
  localparam logic [ADDR_W-1:0] RA_AHOUR  = 8'h1B;
  localparam logic [ADDR_W-1:0] RA_ADAYLO = 8'h1C;
  localparam logic [ADDR_W-1:0] RA_ADAYHI = 8'h1D;

  // control byte bit positions
  localparam int CB_BUSY = 7;
  localparam int CB_DAEN = 5;
  localparam int CB_HAEN = 4;
  localparam int CB_MAEN = 3;
  localparam int CB_FLAG = 2;
  localparam int CB_AIEN = 1;
  localparam int CB_EN   = 0;

  // last value of each BCD field before it wraps
  localparam logic [DATA_W-1:0] SEC_LAST  = 8'h59;
  localparam logic [DATA_W-1:0] MIN_LAST  = 8'h59;
  localparam logic [DATA_W-1:0] HOUR_LAST = 8'h23;
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter int           W    = 8,
  parameter logic [W-1:0] LAST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] next_o,
  output logic         carry_o
);
  localparam int HW = W / 2;

  logic [W-1:0] q;
  logic [W-1:0] stepped;
  logic         at_last;

  // out-of-range loads recover by wrapping on the next step
  assign at_last = (q >= LAST);

  always_comb begin
    if (at_last)
      stepped = '0;
    else if (q[HW-1:0] == HW'(9))
      stepped = {q[W-1:HW] + (W-HW)'(1), HW'(0)};
    else
      stepped = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (ld_i)  q <= ld_d_i;
    else if (inc_i) q <= stepped;
  end

  assign q_o     = q;
  assign next_o  = inc_i ? stepped : q;
  assign carry_o = inc_i & at_last;
endmodule

// File: rtl/cal_day_count.sv
module cal_day_count #(
  parameter int DAY_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [BYTE_W-1:0] ld_d_i,
  output logic [DAY_W-1:0]  q_o,
  output logic [DAY_W-1:0]  next_o
);
  localparam int HI_W = DAY_W - BYTE_W;

  logic [DAY_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (inc_i) begin
      q <= q + DAY_W'(1);
    end else begin
      if (ld_lo_i) q[BYTE_W-1:0]     <= ld_d_i;
      if (ld_hi_i) q[DAY_W-1:BYTE_W] <= ld_d_i[HI_W-1:0];
    end
  end

  assign q_o    = q;
  assign next_o = inc_i ? q + DAY_W'(1) : q;
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp #(
  parameter int BYTE_W = 8,
  parameter int DAY_W  = 15
) (
  input  logic [BYTE_W-1:0] min_i,
  input  logic [BYTE_W-1:0] hour_i,
  input  logic [DAY_W-1:0]  day_i,
  input  logic [BYTE_W-1:0] al_min_i,
  input  logic [BYTE_W-1:0] al_hour_i,
  input  logic [DAY_W-1:0]  al_day_i,
  input  logic [2:0]        en_i,     // {day, hour, minute}
  output logic              hit_o
);
  logic [2:0] eq;

  assign eq[0] = (min_i  == al_min_i);
  assign eq[1] = (hour_i == al_hour_i);
  assign eq[2] = (day_i  == al_day_i);

  // at least one field armed, and every armed field equal
  assign hit_o = (|en_i) & (&(eq | ~en_i));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int HI_W  = DAY_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  // update strobe: one cycle after an enabled tick
  logic upd_q;

  // control state
  logic ctl_en, ctl_aien, ctl_maen, ctl_haen, ctl_daen, alm_flag;

  // one-entry write hold for writes that land on a busy cycle
  logic              hold_v;
  logic [ADDR_W-1:0] hold_a;
  logic [DATA_W-1:0] hold_d;

  logic              wr_go;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;

  assign busy_o = upd_q;
  assign wr_go  = !upd_q && (hold_v || wr_en_i);
  assign wa     = hold_v ? hold_a : addr_i;
  assign wd     = hold_v ? hold_d : wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= tick_i & ctl_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_a <= '0;
      hold_d <= '0;
    end else if (upd_q) begin
      if (wr_en_i) begin
        hold_v <= 1'b1;
        hold_a <= addr_i;
        hold_d <= wdata_i;
      end
    end else if (hold_v) begin
      // the held write drains this cycle; a new one takes its slot
      hold_v <= wr_en_i;
      if (wr_en_i) begin
        hold_a <= addr_i;
        hold_d <= wdata_i;
      end
    end
  end

  // write decode
  logic w_ctrl, w_sec, w_min, w_hour, w_dlo, w_dhi;
  logic w_amin, w_ahour, w_adlo, w_adhi;

  assign w_ctrl  = wr_go && (wa == RA_CTRL);
  assign w_sec   = wr_go && (wa == RA_SEC);
  assign w_min   = wr_go && (wa == RA_MIN);
  assign w_hour  = wr_go && (wa == RA_HOUR);
  assign w_dlo   = wr_go && (wa == RA_DAYLO);
  assign w_dhi   = wr_go && (wa == RA_DAYHI);
  assign w_amin  = wr_go && (wa == RA_AMIN);
  assign w_ahour = wr_go && (wa == RA_AHOUR);
  assign w_adlo  = wr_go && (wa == RA_ADAYLO);
  assign w_adhi  = wr_go && (wa == RA_ADAYHI);

  // counter chain
  logic [DATA_W-1:0] sec_q, min_q, hour_q;
  logic [DATA_W-1:0] sec_nx, min_nx, hour_nx;
  logic              sec_c, min_c, hour_c;
  logic [DAY_W-1:0]  day_q, day_nx;

  cal_bcd_field #(.W(DATA_W), .LAST(SEC_LAST)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc_i(upd_q), .ld_i(w_sec), .ld_d_i(wd),
    .q_o(sec_q), .next_o(sec_nx), .carry_o(sec_c)
  );

  cal_bcd_field #(.W(DATA_W), .LAST(MIN_LAST)) u_min (
    .clk(clk), .rst_n(rst_n), .inc_i(sec_c), .ld_i(w_min), .ld_d_i(wd),
    .q_o(min_q), .next_o(min_nx), .carry_o(min_c)
  );

  cal_bcd_field #(.W(DATA_W), .LAST(HOUR_LAST)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc_i(min_c), .ld_i(w_hour), .ld_d_i(wd),
    .q_o(hour_q), .next_o(hour_nx), .carry_o(hour_c)
  );

  cal_day_count #(.DAY_W(DAY_W), .BYTE_W(DATA_W)) u_day (
    .clk(clk), .rst_n(rst_n), .inc_i(hour_c), .ld_lo_i(w_dlo), .ld_hi_i(w_dhi),
    .ld_d_i(wd), .q_o(day_q), .next_o(day_nx)
  );

  // alarm registers
  logic [DATA_W-1:0] al_min, al_hour;
  logic [DAY_W-1:0]  al_day;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_min  <= '0;
      al_hour <= '0;
      al_day  <= '0;
    end else begin
      if (w_amin)  al_min  <= wd;
      if (w_ahour) al_hour <= wd;
      if (w_adlo)  al_day[DATA_W-1:0]     <= wd;
      if (w_adhi)  al_day[DAY_W-1:DATA_W] <= wd[HI_W-1:0];
    end
  end

  // compare against the values the counters are about to take
  logic alm_hit, alm_set;

  cal_alarm_cmp #(.BYTE_W(DATA_W), .DAY_W(DAY_W)) u_cmp (
    .min_i(min_nx), .hour_i(hour_nx), .day_i(day_nx),
    .al_min_i(al_min), .al_hour_i(al_hour), .al_day_i(al_day),
    .en_i({ctl_daen, ctl_haen, ctl_maen}), .hit_o(alm_hit)
  );

  assign alm_set = sec_c & alm_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_aien <= 1'b0;
      ctl_maen <= 1'b0;
      ctl_haen <= 1'b0;
      ctl_daen <= 1'b0;
      alm_flag <= 1'b0;
    end else begin
      if (w_ctrl) begin
        ctl_en   <= wd[CB_EN];
        ctl_aien <= wd[CB_AIEN];
        ctl_maen <= wd[CB_MAEN];
        ctl_haen <= wd[CB_HAEN];
        ctl_daen <= wd[CB_DAEN];
      end
      // set and clear never share a cycle: writes wait out the busy cycle
      if (alm_set)                     alm_flag <= 1'b1;
      else if (w_ctrl && wd[CB_FLAG])  alm_flag <= 1'b0;
    end
  end

  assign irq_o = alm_flag & ctl_aien;

  // read path
  logic [DATA_W-1:0] ctrl_rd, rd_mux;

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_BUSY] = upd_q;
    ctrl_rd[CB_DAEN] = ctl_daen;
    ctrl_rd[CB_HAEN] = ctl_haen;
    ctrl_rd[CB_MAEN] = ctl_maen;
    ctrl_rd[CB_FLAG] = alm_flag;
    ctrl_rd[CB_AIEN] = ctl_aien;
    ctrl_rd[CB_EN]   = ctl_en;
  end

  always_comb begin
    case (addr_i)
      RA_CTRL:   rd_mux = ctrl_rd;
      RA_SEC:    rd_mux = sec_q;
      RA_MIN:    rd_mux = min_q;
      RA_HOUR:   rd_mux = hour_q;
      RA_DAYLO:  rd_mux = day_q[DATA_W-1:0];
      RA_DAYHI:  rd_mux = {{PAD_W{1'b0}}, day_q[DAY_W-1:DATA_W]};
      RA_AMIN:   rd_mux = al_min;
      RA_AHOUR:  rd_mux = al_hour;
      RA_ADAYLO: rd_mux = al_day[DATA_W-1:0];
      RA_ADAYHI: rd_mux = {{PAD_W{1'b0}}, al_day[DAY_W-1:DATA_W]};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_o <= '0;
    else if (rd_en_i)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       busy,
  input logic       ctl_en,
  input logic       wr_go,
  input logic       flag,
  input logic       aien,
  input logic       irq,
  input logic [7:0] sec
);
  // R8: busy only follows an enabled tick
  a_r8_busy_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($past(tick_i) && $past(ctl_en)));

  // R5 / R8: seconds move only on an update cycle or an applied write
  a_r5_sec_still_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_go) |=> $stable(sec));

  // R10: flag rises only at the end of an update that left seconds at 00
  a_r10_flag_sets_on_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(busy) && sec == 8'h00));

  // R11: flag falls only through an applied register write
  a_r11_flag_clears_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_go));

  // R12: interrupt needs both flag and enable
  a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && aien));
endmodule

bind bcd_calendar cal_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy(busy_o), .ctl_en(ctl_en),
  .wr_go(wr_go), .flag(alm_flag), .aien(ctl_aien), .irq(irq_o), .sec(sec_q)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o, irq_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [7:0] A_CTRL = 8'h14, A_SEC = 8'h15, A_MIN = 8'h16,
    A_HOUR = 8'h17, A_DLO = 8'h18, A_DHI = 8'h19, A_AMIN = 8'h1A,
    A_AHOUR = 8'h1B, A_ADLO = 8'h1C, A_ADHI = 8'h1D;

  always #4 clk = ~clk;  // 125 MHz

  bcd_calendar u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .busy_o(busy_o), .irq_o(irq_o)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // driver: issue a read and queue the expected byte for the monitor
  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    @(negedge clk);
  endtask

  // monitor: read data is valid at the negedge after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en_i) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R13: unexpected read data %02h", rdata_o);
        end else begin
          logic [7:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rdata_o, e, t);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({7'd0, busy_o}, 8'h00, "R1 busy after reset");
    check({7'd0, irq_o},  8'h00, "R1 irq after reset");
    check(rdata_o, 8'h00, "R1 rdata after reset");
    rd(A_CTRL, 8'h00, "R1 ctrl");
    rd(A_SEC,  8'h00, "R1 sec");
    rd(A_DLO,  8'h00, "R1 day low");

    // R6 unmapped address
    wr(8'h30, 8'hAA);
    rd(8'h30, 8'h00, "R6 unmapped read");

    // R5 calendar disabled
    wr(A_SEC, 8'h08);
    tick();
    rd(A_SEC, 8'h08, "R5 no count when disabled");

    // R2 digit carry
    wr(A_CTRL, 8'h01);
    tick();
    rd(A_SEC, 8'h09, "R2 sec 08->09");
    tick();
    rd(A_SEC, 8'h10, "R2 sec 09->10");

    // R2 R3 R4 full rollover with day wrap
    wr(A_SEC, 8'h59); wr(A_MIN, 8'h59); wr(A_HOUR, 8'h23);
    wr(A_DLO, 8'hFF); wr(A_DHI, 8'hFF);
    rd(A_DHI, 8'h7F, "R4 day high bit7 dropped");
    tick();
    rd(A_SEC,  8'h00, "R2 sec 59->00");
    rd(A_MIN,  8'h00, "R2 min 59->00");
    rd(A_HOUR, 8'h00, "R3 hour 23->00");
    rd(A_DLO,  8'h00, "R4 day wrap low");
    rd(A_DHI,  8'h00, "R4 day wrap high");

    // R3 hour carry without day carry
    wr(A_SEC, 8'h59); wr(A_MIN, 8'h59); wr(A_HOUR, 8'h09);
    wr(A_DLO, 8'h10); wr(A_DHI, 8'h00);
    tick();
    rd(A_HOUR, 8'h10, "R3 hour 09->10");
    rd(A_DLO,  8'h10, "R3 no day carry");

    // R8 busy for one cycle, visible in control bit 7
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    check({7'd0, busy_o}, 8'h01, "R8 busy high");
    rd_en_i = 1'b1; addr_i = A_CTRL;
    exp_q.push_back(8'h81); tag_q.push_back("R8 ctrl busy bit");
    @(negedge clk); rd_en_i = 1'b0;
    check({7'd0, busy_o}, 8'h00, "R8 busy drops");
    rd(A_SEC, 8'h01, "R8 sec advanced");

    // R9 write during busy wins over the increment
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    wr_en_i = 1'b1; addr_i = A_SEC; wdata_i = 8'h30;
    @(negedge clk); wr_en_i = 1'b0;
    @(negedge clk);
    rd(A_SEC, 8'h30, "R9 held write applied");

    // R10 R12 minute+hour alarm
    wr(A_AMIN, 8'h05); wr(A_AHOUR, 8'h01); wr(A_ADLO, 8'h00); wr(A_ADHI, 8'h00);
    rd(A_AMIN, 8'h05, "R6 alarm minute readback");
    wr(A_HOUR, 8'h01); wr(A_MIN, 8'h04); wr(A_SEC, 8'h59);
    wr(A_DLO, 8'h00);
    wr(A_CTRL, 8'h1B);
    rd(A_CTRL, 8'h1B, "R7 ctrl layout");
    check({7'd0, irq_o}, 8'h00, "R12 irq low before match");
    tick();
    check({7'd0, irq_o}, 8'h01, "R12 irq on match");
    rd(A_CTRL, 8'h1F, "R10 flag set on match");

    // R11 write 0 keeps, write 1 clears, no re-set in same minute
    wr(A_CTRL, 8'h1B);
    rd(A_CTRL, 8'h1F, "R11 write 0 keeps flag");
    wr(A_CTRL, 8'h1F);
    rd(A_CTRL, 8'h1B, "R11 write 1 clears flag");
    check({7'd0, irq_o}, 8'h00, "R12 irq low after clear");
    tick();
    rd(A_CTRL, 8'h1B, "R11 no second set");

    // R10 day enabled but different
    wr(A_CTRL, 8'h3B);
    wr(A_DLO, 8'h05); wr(A_MIN, 8'h04); wr(A_SEC, 8'h59);
    tick();
    rd(A_CTRL, 8'h3B, "R10 day mismatch no flag");

    // R10 disabled field ignored (hour differs)
    wr(A_CTRL, 8'h0B);
    wr(A_HOUR, 8'h07); wr(A_MIN, 8'h04); wr(A_SEC, 8'h59);
    tick();
    rd(A_CTRL, 8'h0F, "R10 disabled hour ignored");
    wr(A_CTRL, 8'h0F);

    // R12 interrupt disabled
    wr(A_CTRL, 8'h09);
    wr(A_MIN, 8'h04); wr(A_SEC, 8'h59);
    tick();
    check({7'd0, irq_o}, 8'h00, "R12 irq masked");
    rd(A_CTRL, 8'h0D, "R12 flag set while masked");

    // R10 no compare enabled
    wr(A_CTRL, 8'h05);
    rd(A_CTRL, 8'h01, "R11 clear with enables off");
    wr(A_MIN, 8'h04); wr(A_SEC, 8'h59);
    tick();
    rd(A_CTRL, 8'h01, "R10 no enable no flag");

    // R10 day-only match using both day bytes
    wr(A_ADLO, 8'h34); wr(A_ADHI, 8'h12);
    wr(A_DLO, 8'h34);  wr(A_DHI, 8'h12);
    wr(A_CTRL, 8'h23);
    wr(A_MIN, 8'h10); wr(A_SEC, 8'h59);
    tick();
    rd(A_CTRL, 8'h27, "R10 day match");
    rd(A_ADHI, 8'h12, "R6 alarm day high readback");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R13: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule